// File: doc/BRIEF.md
# Unlock Sequence Detector for a Parallel EEPROM Write Path

This block sits between the host-side byte-write path of a parallel EEPROM and its page buffer. Each accepted bus write comes in as one beat (address plus data) on a valid/ready stream. The block checks that stream against two fixed unlock command sequences. A three-step sequence both turns protection on and opens one page-write window. A six-step sequence raises a one-cycle chip-erase trigger.

Writes that are allowed to reach the page buffer leave on a second valid/ready stream. A write is allowed when the device is unprotected or a page-write window is open. Back-pressure rules:
- The input is ready whenever the beat will be dropped or consumed as a command step.
- When the beat will be forwarded, input ready follows output ready.
- A beat takes effect only on a cycle with valid and ready both high.

The page-write engine reports with a one-cycle commit strobe that its commit has finished. That strobe closes the window, and the device is then protected again.

Top module: `sdp_seq_detector`

## Requirements
- R1: After reset, `protected_o`, `write_permit` and `erase_start` are 0.
- R2: While unprotected and no window is open, a write that is not the expected next command step is forwarded: `ld_valid` equals `wr_valid`, `ld_addr`/`ld_data` equal `wr_addr`/`wr_data`, and `wr_ready` equals `ld_ready`.
- R3: The write sequence is data AAh at address 5555h, then 55h at 2AAAh, then A0h at 5555h. Only address bits 14:0 are compared. One cycle after the third step is accepted, `protected_o` and `write_permit` are 1. Command steps are never forwarded.
- R4: While `write_permit` is 1, every write is forwarded whatever its address or data, and sequence tracking is suspended.
- R5: `write_permit` is 0 in the cycle after `commit_done` is sampled high. `commit_done` has no effect while no window is open.
- R6: While protected with no window open, a non-step write is dropped: `ld_valid` is 0 and `wr_ready` is 1.
- R7: A write that does not match the next expected step returns tracking to idle. That write is not counted as a first step, even if it is AAh at 5555h.
- R8: The erase sequence is AAh/5555h, 55h/2AAAh, 80h/5555h, AAh/5555h, 55h/2AAAh, 10h/5555h. `erase_start` is high for exactly the one cycle after its last step is accepted. Protection and the window are unchanged.
- R9: Once set, protection stays set until reset. Each repeat of the write sequence opens exactly one more window.
- R10: A forwarded write that is stalled (`ld_ready` 0) is not accepted and does not advance or abort the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write beat valid |
| wr_ready | output | 1 | Write beat accepted when high with valid |
| wr_addr | input | ADDR_W | Latched write address |
| wr_data | input | DATA_W | Latched write data |
| ld_valid | output | 1 | Forwarded load valid |
| ld_ready | input | 1 | Page buffer ready |
| ld_addr | output | ADDR_W | Forwarded load address |
| ld_data | output | DATA_W | Forwarded load data |
| commit_done | input | 1 | Page-write commit finished |
| write_permit | output | 1 | One page-write window open |
| protected_o | output | 1 | Protection enabled |
| erase_start | output | 1 | One-cycle chip-erase trigger |

## Verification
Directed runs cover four situations:
- Complete write and erase sequences, to tell the two terminal steps apart.
- A broken sequence whose breaking byte is itself a valid first step, to show that an abort does not re-arm the detector.
- Command-looking bytes sent while a window is open, to show that tracking is suspended.
- Stalled forwards, to separate an offered beat from an accepted one.

Seeded random beats are then drawn mostly from the command vocabulary, mixed with random addresses, aliased upper address bits, random stalls and commit strobes. This reaches partial sequences, aborts and repeated unlocks in many orders. A bench model judges every beat.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  localparam int CMD_AW = 15;
  localparam logic [CMD_AW-1:0] ADR_HI = 15'h5555;
  localparam logic [CMD_AW-1:0] ADR_LO = 15'h2AAA;
  localparam logic [7:0] B_KEY1  = 8'hAA;
  localparam logic [7:0] B_KEY2  = 8'h55;
  localparam logic [7:0] B_WRITE = 8'hA0;
  localparam logic [7:0] B_ERPRE = 8'h80;
  localparam logic [7:0] B_ERASE = 8'h10;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_E3, SQ_E4, SQ_E5
  } seq_state_e;
endpackage

// File: rtl/sdp_step_match.sv
module sdp_step_match
  import sdp_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  seq_state_e        state,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              hit,
  output seq_state_e        nxt,
  output logic              wr_done,
  output logic              er_done
);
  localparam int CW = (ADDR_W < CMD_AW) ? ADDR_W : CMD_AW;

  logic [CMD_AW-1:0] cmd_a;
  logic [7:0]        cmd_d;
  logic              at_hi, at_lo;

  generate
    if (ADDR_W >= CMD_AW) begin : g_addr_full
      assign cmd_a = addr[CMD_AW-1:0];
    end else begin : g_addr_pad
      assign cmd_a = {{(CMD_AW-CW){1'b0}}, addr[CW-1:0]};
    end
    if (DATA_W >= 8) begin : g_data_full
      assign cmd_d = data[7:0];
    end else begin : g_data_pad
      assign cmd_d = {{(8-DATA_W){1'b0}}, data};
    end
  endgenerate

  assign at_hi = (cmd_a == ADR_HI);
  assign at_lo = (cmd_a == ADR_LO);

  always_comb begin
    hit     = 1'b0;
    nxt     = SQ_IDLE;
    wr_done = 1'b0;
    er_done = 1'b0;
    unique case (state)
      SQ_IDLE: if (at_hi && cmd_d == B_KEY1) begin hit = 1'b1; nxt = SQ_U1; end
      SQ_U1:   if (at_lo && cmd_d == B_KEY2) begin hit = 1'b1; nxt = SQ_U2; end
      SQ_U2: begin
        if (at_hi && cmd_d == B_WRITE) begin
          hit = 1'b1; wr_done = 1'b1;
        end else if (at_hi && cmd_d == B_ERPRE) begin
          hit = 1'b1; nxt = SQ_E3;
        end
      end
      SQ_E3:   if (at_hi && cmd_d == B_KEY1) begin hit = 1'b1; nxt = SQ_E4; end
      SQ_E4:   if (at_lo && cmd_d == B_KEY2) begin hit = 1'b1; nxt = SQ_E5; end
      SQ_E5:   if (at_hi && cmd_d == B_ERASE) begin hit = 1'b1; er_done = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/sdp_seq_fsm.sv
module sdp_seq_fsm
  import sdp_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              track,
  input  logic              take,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              hit,
  output logic              wr_fire,
  output logic              er_fire
);
  seq_state_e state_q, nxt;
  logic       m_hit, m_wr, m_er;

  sdp_step_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .state  (state_q),
    .addr   (addr),
    .data   (data),
    .hit    (m_hit),
    .nxt    (nxt),
    .wr_done(m_wr),
    .er_done(m_er)
  );

  assign hit     = track & m_hit;
  assign wr_fire = take & hit & m_wr;
  assign er_fire = take & hit & m_er;

  always_ff @(posedge clk) begin
    if (!rst_n || !track) state_q <= SQ_IDLE;
    else if (take)        state_q <= nxt;
  end
endmodule

// File: rtl/sdp_prot_ctrl.sv
module sdp_prot_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_fire,
  input  logic er_fire,
  input  logic commit_done,
  output logic prot_q,
  output logic permit_q,
  output logic erase_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prot_q   <= 1'b0;
      permit_q <= 1'b0;
      erase_q  <= 1'b0;
    end else begin
      erase_q <= er_fire;
      if (wr_fire) begin
        prot_q   <= 1'b1;
        permit_q <= 1'b1;
      end else if (commit_done) begin
        permit_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdp_load_gate.sv
module sdp_load_gate (
  input  logic wr_valid,
  input  logic permit,
  input  logic prot,
  input  logic hit,
  input  logic ld_ready,
  output logic wr_ready,
  output logic ld_valid,
  output logic take
);
  logic fwd;
  assign fwd      = permit | (~prot & ~hit);
  assign ld_valid = wr_valid & fwd;
  assign wr_ready = fwd ? ld_ready : 1'b1;
  assign take     = wr_valid & wr_ready;
endmodule

// File: rtl/sdp_seq_detector.sv
module sdp_seq_detector #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ld_valid,
  input  logic              ld_ready,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [DATA_W-1:0] ld_data,
  input  logic              commit_done,
  output logic              write_permit,
  output logic              protected_o,
  output logic              erase_start
);
  logic hit, take, wr_fire, er_fire;

  sdp_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .track  (~write_permit),
    .take   (take),
    .addr   (wr_addr),
    .data   (wr_data),
    .hit    (hit),
    .wr_fire(wr_fire),
    .er_fire(er_fire)
  );

  sdp_load_gate u_gate (
    .wr_valid(wr_valid),
    .permit  (write_permit),
    .prot    (protected_o),
    .hit     (hit),
    .ld_ready(ld_ready),
    .wr_ready(wr_ready),
    .ld_valid(ld_valid),
    .take    (take)
  );

  sdp_prot_ctrl u_prot (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_fire    (wr_fire),
    .er_fire    (er_fire),
    .commit_done(commit_done),
    .prot_q     (protected_o),
    .permit_q   (write_permit),
    .erase_q    (erase_start)
  );

  assign ld_addr = wr_addr;
  assign ld_data = wr_data;
endmodule

// File: rtl/sdp_seq_detector_chk.sv
module sdp_seq_detector_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_valid,
  input logic wr_ready,
  input logic ld_valid,
  input logic ld_ready,
  input logic commit_done,
  input logic write_permit,
  input logic protected_o,
  input logic erase_start
);
  a_r8_erase_single: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);
  a_r9_prot_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    protected_o |=> protected_o);
  a_r3_permit_protected: assert property (@(posedge clk) disable iff (!rst_n)
    write_permit |-> protected_o);
  a_r5_commit_release: assert property (@(posedge clk) disable iff (!rst_n)
    (write_permit && commit_done) |=> !write_permit);
  a_r6_drop_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (protected_o && !write_permit) |-> !ld_valid);
  a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !ld_ready) |-> !wr_ready);
  a_r4_window_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    (write_permit && wr_valid) |-> ld_valid);
endmodule

bind sdp_seq_detector sdp_seq_detector_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .ld_valid    (ld_valid),
  .ld_ready    (ld_ready),
  .commit_done (commit_done),
  .write_permit(write_permit),
  .protected_o (protected_o),
  .erase_start (erase_start)
);

// File: tb/sdp_seq_detector_bench.sv
module sdp_seq_detector_bench;
  localparam int AW = 18;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, ld_ready = 1'b1, commit_done = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, ld_valid, write_permit, protected_o, erase_start;
  logic [AW-1:0] ld_addr;
  logic [DW-1:0] ld_data;

  int n_chk = 0, n_bad = 0;
  int mstep = 0;
  bit mprot = 0, mperm = 0;

  always #10 clk = ~clk;

  sdp_seq_detector #(.ADDR_W(AW), .DATA_W(DW)) u_sdp_seq_detector (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .ld_valid(ld_valid),
    .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_data(ld_data),
    .commit_done(commit_done), .write_permit(write_permit),
    .protected_o(protected_o), .erase_start(erase_start)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Model of the command steps (R3, R7, R8)
  function automatic void mdl_step(input int st, input logic [AW-1:0] a,
      input logic [7:0] d, output bit h, output int nx, output bit wd, output bit ed);
    logic [14:0] la;
    la = a[14:0];
    h = 0; nx = 0; wd = 0; ed = 0;
    case (st)
      0: if (la == 15'h5555 && d == 8'hAA) begin h = 1; nx = 1; end
      1: if (la == 15'h2AAA && d == 8'h55) begin h = 1; nx = 2; end
      2: if (la == 15'h5555 && d == 8'hA0) begin h = 1; wd = 1; end
         else if (la == 15'h5555 && d == 8'h80) begin h = 1; nx = 3; end
      3: if (la == 15'h5555 && d == 8'hAA) begin h = 1; nx = 4; end
      4: if (la == 15'h2AAA && d == 8'h55) begin h = 1; nx = 5; end
      5: if (la == 15'h5555 && d == 8'h10) begin h = 1; ed = 1; end
      default: ;
    endcase
  endfunction

  task automatic do_wr(input logic [AW-1:0] a, input logic [7:0] d,
                       input bit rdy, input string req);
    bit h, wd, ed, fwd, acc, eexp;
    int nx;
    mdl_step(mstep, a, d, h, nx, wd, ed);
    if (mperm) h = 0;
    fwd = mperm | (!mprot & !h);
    wr_addr = a; wr_data = d; wr_valid = 1'b1; ld_ready = rdy;
    #2;
    chk(ld_valid == fwd, req, "ld_valid", ld_valid, fwd);
    chk(wr_ready == (fwd ? rdy : 1'b1), req, "wr_ready", wr_ready, fwd ? rdy : 1'b1);
    if (fwd) chk(ld_addr == a && ld_data == d, req, "ld_addr/data",
                 {ld_addr, ld_data}, {a, d});
    @(negedge clk);
    wr_valid = 1'b0;
    acc = !fwd | rdy;
    eexp = 0;
    if (acc && !mperm) begin
      if (h) begin
        mstep = nx;
        if (wd) begin mprot = 1; mperm = 1; end
        if (ed) eexp = 1;
      end else mstep = 0;
    end
    chk(protected_o == mprot, req, "protected_o", protected_o, mprot);
    chk(write_permit == mperm, req, "write_permit", write_permit, mperm);
    chk(erase_start == eexp, req, "erase_start", erase_start, eexp);
  endtask

  task automatic do_commit(input string req);
    commit_done = 1'b1;
    @(negedge clk);
    commit_done = 1'b0;
    mperm = 0;
    chk(write_permit == 1'b0, req, "write_permit after commit", write_permit, 0);
    chk(protected_o == mprot, req, "protected_o after commit", protected_o, mprot);
  endtask

  task automatic unlock(input string req);
    do_wr(18'h05555, 8'hAA, 1, req);
    do_wr(18'h02AAA, 8'h55, 1, req);
    do_wr(18'h05555, 8'hA0, 1, req);
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(protected_o == 0, "R1", "protected_o", protected_o, 0);
    chk(write_permit == 0, "R1", "write_permit", write_permit, 0);
    chk(erase_start == 0, "R1", "erase_start", erase_start, 0);
    // R2 unprotected passthrough
    do_wr(18'h12345, 8'h3C, 1, "R2");
    do_wr(18'h00010, 8'hF0, 1, "R2");
    // R10 stalled forward leaves the partial sequence intact
    do_wr(18'h05555, 8'hAA, 1, "R10");
    do_wr(18'h00777, 8'h01, 0, "R10");
    do_wr(18'h02AAA, 8'h55, 1, "R10");
    do_wr(18'h05555, 8'h80, 1, "R10");
    do_wr(18'h05555, 8'hAA, 1, "R8");
    do_wr(18'h02AAA, 8'h55, 1, "R8");
    do_wr(18'h05555, 8'h10, 1, "R8");
    @(negedge clk);
    chk(erase_start == 0, "R8", "erase_start second cycle", erase_start, 0);
    // R5 stray commit ignored
    do_commit("R5");
    // R3 write unlock with aliased upper address bits
    do_wr(18'h35555, 8'hAA, 1, "R3");
    do_wr(18'h22AAA, 8'h55, 1, "R3");
    do_wr(18'h15555, 8'hA0, 1, "R3");
    // R4 command-looking bytes in the window are forwarded
    do_wr(18'h05555, 8'hAA, 1, "R4");
    do_wr(18'h02AAA, 8'h55, 0, "R4");
    do_wr(18'h01F00, 8'h77, 1, "R4");
    do_commit("R5");
    // R6 locked drop
    do_wr(18'h01F01, 8'h99, 1, "R6");
    do_wr(18'h01F02, 8'h98, 0, "R6");
    // R7 abort by a byte that is itself a first step
    do_wr(18'h05555, 8'hAA, 1, "R7");
    do_wr(18'h05555, 8'hAA, 1, "R7");
    do_wr(18'h02AAA, 8'h55, 1, "R7");
    do_wr(18'h05555, 8'hA0, 1, "R7");
    do_wr(18'h00001, 8'h00, 1, "R7");
    // R9 repeated unlock reopens one window
    unlock("R9");
    do_wr(18'h00400, 8'h5A, 1, "R9");
    do_commit("R9");
    do_wr(18'h00401, 8'h5B, 1, "R9");
    // Random phase
    for (int i = 0; i < 600; i++) begin
      int r, k;
      logic [AW-1:0] a;
      logic [7:0] d;
      r = $urandom % 12;
      if (r == 0) do_commit("R5");
      else begin
        k = $urandom % 8;
        case (k)
          0: begin a = 18'h05555; d = 8'hAA; end
          1: begin a = 18'h02AAA; d = 8'h55; end
          2: begin a = 18'h05555; d = 8'hA0; end
          3: begin a = 18'h05555; d = 8'h80; end
          4: begin a = 18'h05555; d = 8'h10; end
          5: begin a = {3'($urandom), 15'h5555}; d = 8'hAA; end
          default: begin a = 18'($urandom); d = 8'($urandom); end
        endcase
        do_wr(a, d, ($urandom % 4) != 0, "R2/R3/R4/R6/R7/R8 random");
      end
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule